// File: doc/BRIEF.md
# Content-Addressable Memory Array

This block is a small register-based store that serves two roles. As an ordinary memory it takes an address and a data word: a write stores the word in the selected slot, and a read returns the selected slot. As a content-addressable memory it takes the same data input as a search key and checks that key against every stored word in one cycle. The result is a vector with one bit per word, where more than one bit may be set, together with a miss flag that is high when no bit is set.

Each slot has a valid flag. Slots that have never been written do not match any key, including a key of all zeros. Only one operation runs in a cycle. When several are requested together, a write goes first, then a compare, then a read, and the requests that lose produce no result. Read and compare results are registered. They appear one clock after the request, each with a single-cycle valid pulse, and they hold their value until the next result of the same kind.

Top module: `cam_array`

## Requirements
- R1: A write stores `data_in` in the slot selected by `addr`. A later read of that slot drives the stored word on `rd_data` one clock after the read request, with `rd_valid` high for that one cycle.
- R2: Reading a slot that has never been written since reset returns zero.
- R3: A compare drives `cmp_valid` high for one cycle, one clock after the request. In that cycle bit i of `match_vec` is 1 exactly when slot i is valid and equal to the key.
- R4: `miss` is 1 exactly when every bit of `match_vec` is 0.
- R5: A slot that has never been written never matches, whatever the key is, including all zeros.
- R6: A compare leaves the stored contents unchanged, so a read after it returns the value written before it.
- R7: Only one operation runs per cycle, in the order write, then compare, then read. A request that loses to another gives no valid pulse, and the winning write still takes effect.
- R8: Outside their result cycles, `match_vec` and `miss` keep the last compare result and `rd_data` keeps the last read result.
- R9: After reset, `match_vec` is 0, `miss` is 1, `rd_data` is 0, both valid pulses are low, and every slot is empty.
- R10: When several valid slots hold the key, every one of them sets its bit in `match_vec`.
- R11: A match needs equality across the whole word width. A key that differs from a stored word in a single bit does not match that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Slot select for read and write |
| data_in | input | WIDTH | Data to write, or the key for a compare |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| cmp_en | input | 1 | Compare request |
| rd_data | output | WIDTH | Registered read result |
| rd_valid | output | 1 | One-cycle pulse marking a new read result |
| match_vec | output | WORDS | Registered per-slot match result |
| miss | output | 1 | High when no slot matched |
| cmp_valid | output | 1 | One-cycle pulse marking a new compare result |

## Verification
Compares are run with several kinds of key:
- Keys issued before any write show whether unwritten slots are wrongly counted as hits.
- A key stored in two slots shows whether a multi-hot result is reported, as opposed to a single hit.
- Keys one bit away from a stored word show whether the compare checks the full width.
- A key that matches nothing shows whether `miss` is driven correctly.

Reads after the compares show whether a compare disturbs the stored contents. Requests that collide in the same cycle show whether the priority order is applied. Idle cycles between operations show whether the registered results hold their value.

// File: rtl/cam_pkg.sv
package cam_pkg;

    // The operation chosen for the current cycle after arbitration.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_CMP   = 2'd2,
        OP_READ  = 2'd3
    } cam_op_e;

endpackage

// File: rtl/cam_op_decode.sv
module cam_op_decode
    import cam_pkg::*;
(
    input  logic    wr_req,
    input  logic    cmp_req,
    input  logic    rd_req,
    output cam_op_e op
);

    // Fixed priority: a write wins over a compare, and a compare wins over a read.
    always_comb begin
        op = OP_IDLE;
        if (wr_req) begin
            op = OP_WRITE;
        end else if (cmp_req) begin
            op = OP_CMP;
        end else if (rd_req) begin
            op = OP_READ;
        end
    end

endmodule

// File: rtl/cam_word.sv
module cam_word #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] key,
    output logic [WIDTH-1:0] word,
    output logic             hit
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             occupied;
    } slot_t;

    slot_t slot_d, slot_q;
    logic [WIDTH-1:0] bit_eq;

    // Next-state logic: a load stores the word and marks the slot as occupied.
    always_comb begin
        slot_d = slot_q;
        if (load) begin
            slot_d.data     = wdata;
            slot_d.occupied = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    // One equality cell per bit. The match line is the AND of all cells,
    // qualified by the occupied flag.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign bit_eq[b] = ~(slot_q.data[b] ^ key[b]);
    end

    assign hit  = slot_q.occupied & (&bit_eq);
    assign word = slot_q.data;

endmodule

// File: rtl/cam_read_mux.sv
module cam_read_mux #(
    parameter int WORDS  = 4,
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 2
) (
    input  logic [WORDS-1:0][WIDTH-1:0] words,
    input  logic [ADDR_W-1:0]           addr,
    output logic [WIDTH-1:0]            rdata
);

    // An address that selects no slot reads as zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (addr == ADDR_W'(i)) begin
                rdata = words[i];
            end
        end
    end

endmodule

// File: rtl/cam_array.sv
module cam_array
    import cam_pkg::*;
#(
    parameter int WORDS  = 4,
    parameter int WIDTH  = 8,
    parameter int ADDR_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  data_in,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              cmp_en,
    output logic [WIDTH-1:0]  rd_data,
    output logic              rd_valid,
    output logic [WORDS-1:0]  match_vec,
    output logic              miss,
    output logic              cmp_valid
);

    typedef struct packed {
        logic [WIDTH-1:0] rd_data;
        logic             rd_valid;
        logic [WORDS-1:0] match;
        logic             miss;
        logic             cmp_valid;
    } result_t;

    cam_op_e                     op;
    logic [WORDS-1:0]            load;
    logic [WORDS-1:0]            hits;
    logic [WORDS-1:0][WIDTH-1:0] words;
    logic [WIDTH-1:0]            sel_word;
    result_t                     res_d, res_q;

    cam_op_decode u_decode (
        .wr_req  (wr_en),
        .cmp_req (cmp_en),
        .rd_req  (rd_en),
        .op      (op)
    );

    // One storage slot and comparator per word. A slot loads only on a
    // write that addresses it, so a compare can never change a slot.
    for (genvar i = 0; i < WORDS; i++) begin : g_slot
        assign load[i] = (op == OP_WRITE) && (addr == ADDR_W'(i));

        cam_word #(.WIDTH(WIDTH)) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load[i]),
            .wdata (data_in),
            .key   (data_in),
            .word  (words[i]),
            .hit   (hits[i])
        );
    end

    cam_read_mux #(.WORDS(WORDS), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_rmux (
        .words (words),
        .addr  (addr),
        .rdata (sel_word)
    );

    // Result registers: the valid pulses last one cycle, and the data
    // fields hold until the next result of the same kind.
    always_comb begin
        res_d           = res_q;
        res_d.rd_valid  = 1'b0;
        res_d.cmp_valid = 1'b0;
        unique case (op)
            OP_CMP: begin
                res_d.match     = hits;
                res_d.miss      = ~|hits;
                res_d.cmp_valid = 1'b1;
            end
            OP_READ: begin
                res_d.rd_data  = sel_word;
                res_d.rd_valid = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q      <= '0;
            res_q.miss <= 1'b1;
        end else begin
            res_q <= res_d;
        end
    end

    assign rd_data   = res_q.rd_data;
    assign rd_valid  = res_q.rd_valid;
    assign match_vec = res_q.match;
    assign miss      = res_q.miss;
    assign cmp_valid = res_q.cmp_valid;

endmodule

// File: rtl/cam_array_chk.sv
module cam_array_chk #(
    parameter int WORDS  = 4,
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [WIDTH-1:0]  data_in,
    input logic              wr_en,
    input logic              rd_en,
    input logic              cmp_en,
    input logic [WIDTH-1:0]  rd_data,
    input logic              rd_valid,
    input logic [WORDS-1:0]  match_vec,
    input logic              miss,
    input logic              cmp_valid
);

    p_miss_nor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        miss == (match_vec == '0));

    p_cmp_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && !wr_en) |=> cmp_valid);

    p_read_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && !cmp_en) |=> rd_valid);

    p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!cmp_valid && !rd_valid));

    p_cmp_over_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && !wr_en) |=> !rd_valid);

    p_one_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && cmp_valid));

    p_match_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_en && !wr_en) |=> ($stable(match_vec) && $stable(miss)));

    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !wr_en && !cmp_en) |=> $stable(rd_data));

endmodule

bind cam_array cam_array_chk #(.WORDS(WORDS), .WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .data_in   (data_in),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .cmp_en    (cmp_en),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .match_vec (match_vec),
    .miss      (miss),
    .cmp_valid (cmp_valid)
);

// File: tb/cam_array_tb.sv
module cam_array_tb;

    localparam int WORDS  = 4;
    localparam int WIDTH  = 8;
    localparam int ADDR_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [WIDTH-1:0]  data_in = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic              cmp_en = 1'b0;
    logic [WIDTH-1:0]  rd_data;
    logic              rd_valid;
    logic [WORDS-1:0]  match_vec;
    logic              miss;
    logic              cmp_valid;

    always #4 clk = ~clk;  // 125 MHz

    cam_array #(.WORDS(WORDS), .WIDTH(WIDTH)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .data_in   (data_in),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .cmp_en    (cmp_en),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .match_vec (match_vec),
        .miss      (miss),
        .cmp_valid (cmp_valid)
    );

    // Expected result for one issued cycle.
    typedef struct {
        logic             exp_rv;
        logic             exp_cv;
        logic [WIDTH-1:0] exp_rd;
        logic [WORDS-1:0] exp_match;
        logic             exp_miss;
        string            req;
    } exp_t;

    exp_t queue_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    // Reference model, built from the requirements.
    logic [WIDTH-1:0] m_mem [WORDS];
    logic             m_vld [WORDS];
    logic [WIDTH-1:0] m_rd = '0;
    logic [WORDS-1:0] m_match = '0;
    logic             m_miss = 1'b1;

    task automatic do_op(input logic w, input logic r, input logic c,
                         input int a, input logic [WIDTH-1:0] d, input string req);
        exp_t e;
        @(negedge clk);
        wr_en = w; rd_en = r; cmp_en = c;
        addr = ADDR_W'(a); data_in = d;
        e.exp_rv = 1'b0;
        e.exp_cv = 1'b0;
        if (w) begin
            m_mem[a] = d;
            m_vld[a] = 1'b1;
        end else if (c) begin
            for (int i = 0; i < WORDS; i++) begin
                m_match[i] = m_vld[i] && (m_mem[i] == d);
            end
            m_miss = (m_match == '0);
            e.exp_cv = 1'b1;
        end else if (r) begin
            m_rd = m_vld[a] ? m_mem[a] : '0;
            e.exp_rv = 1'b1;
        end
        e.exp_rd    = m_rd;
        e.exp_match = m_match;
        e.exp_miss  = m_miss;
        e.req       = req;
        queue_q.push_back(e);
    endtask

    // Monitor: takes one expected item per issued cycle, just after the
    // edge that registers that cycle's result.
    always @(posedge clk) begin
        #2;
        if (queue_q.size() > 0) begin
            exp_t e;
            e = queue_q.pop_front();
            checks++;
            if (rd_valid !== e.exp_rv || cmp_valid !== e.exp_cv ||
                rd_data !== e.exp_rd || match_vec !== e.exp_match ||
                miss !== e.exp_miss) begin
                errors++;
                $display("FAIL %s: got rv=%b cv=%b rd=%h match=%b miss=%b, expected rv=%b cv=%b rd=%h match=%b miss=%b",
                         e.req, rd_valid, cmp_valid, rd_data, match_vec, miss,
                         e.exp_rv, e.exp_cv, e.exp_rd, e.exp_match, e.exp_miss);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            m_mem[i] = '0;
            m_vld[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: state after reset
        checks++;
        if (rd_valid !== 1'b0 || cmp_valid !== 1'b0 || match_vec !== '0 ||
            miss !== 1'b1 || rd_data !== '0) begin
            errors++;
            $display("FAIL R9: got rv=%b cv=%b match=%b miss=%b rd=%h, expected 0 0 0000 1 00",
                     rd_valid, cmp_valid, match_vec, miss, rd_data);
        end

        do_op(0, 1, 0, 2, 8'h00, "R2 read of unwritten slot");
        do_op(0, 0, 1, 0, 8'h00, "R5 zero key before any write");
        do_op(0, 0, 1, 0, 8'hA5, "R5 key before any write");

        do_op(1, 0, 0, 0, 8'hA5, "R1 write slot 0");
        do_op(1, 0, 0, 1, 8'h3C, "R1 write slot 1");
        do_op(0, 0, 1, 0, 8'h00, "R5 zero key with two slots still empty");
        do_op(1, 0, 0, 2, 8'hA5, "R1 write slot 2");
        do_op(1, 0, 0, 3, 8'hFF, "R1 write slot 3");
        for (int i = 0; i < WORDS; i++) do_op(0, 1, 0, i, 8'h00, "R1 read back");

        do_op(0, 0, 1, 0, 8'hA5, "R10 key held by two slots");
        do_op(0, 0, 1, 0, 8'h3C, "R3 single match");
        do_op(0, 0, 1, 0, 8'hFF, "R3 match on top slot");
        do_op(0, 0, 1, 0, 8'h00, "R4 key with no match");
        do_op(0, 0, 1, 0, 8'hA4, "R11 low bit differs");
        do_op(0, 0, 1, 0, 8'h7F, "R11 high bit differs");
        for (int i = 0; i < WORDS; i++) do_op(0, 1, 0, i, 8'h00, "R6 contents after compares");

        do_op(0, 0, 1, 0, 8'h3C, "R3 compare before idle");
        do_op(0, 1, 0, 3, 8'h00, "R1 read before idle");
        repeat (3) do_op(0, 0, 0, 0, 8'h55, "R8 hold during idle");

        do_op(1, 0, 1, 1, 8'hA5, "R7 write beats compare");
        do_op(0, 0, 1, 0, 8'hA5, "R7 compare sees write");
        do_op(0, 1, 1, 3, 8'hFF, "R7 compare beats read");
        do_op(1, 1, 0, 0, 8'h11, "R7 write beats read");
        do_op(1, 1, 1, 2, 8'h22, "R7 write beats both");
        do_op(0, 0, 1, 0, 8'hA5, "R10 after overwrites");
        do_op(0, 1, 0, 0, 8'h00, "R1 overwrite of slot 0");
        do_op(0, 1, 0, 2, 8'h00, "R1 overwrite of slot 2");
        do_op(0, 0, 0, 0, 8'h00, "R8 final hold");

        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; cmp_en = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule